// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the command front end of a memory controller that serves two arrays: a program flash array and a data EEPROM array. A host writes a command code, a target address and a data word into holding registers, then writes a launch strobe. The controller checks the sequence, runs a fixed-length placeholder algorithm, and then applies the result to a small internal word store that stands in for both arrays. A command-complete flag, `ccif`, is low while an operation runs.

While an operation runs, the controller also decides which host reads may proceed. A normal flash read may overlap a word program or sector erase on the EEPROM, which gives read-while-write. A read of the array being worked on is answered as invalid and raises two sticky fault flags. Any other overlap is refused with a one-cycle bus error and leaves the block's state unchanged.

The sequencer has three states. In `S_IDLE` the flag is high and the block accepts register writes. An accepted launch moves it to `S_EXEC`, where a cycle counter runs down. When the counter expires it moves to `S_COMMIT`, where the store is updated and the interrupt pulse is raised. It then returns to `S_IDLE`. A refused launch leaves it in `S_IDLE`.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset `ccif` is 1, `accerr`, `fpviol`, `sfd`, `dfd` and `bus_err` are 0, the divider is marked unset, and every word of both arrays reads 0xFFFF.
- R2: A launch (`wr_sel`=4) before any write to the divider register (`wr_sel`=0) sets `accerr` one cycle later and runs no operation (`ccif` stays 1).
- R3: Writing a command code (`wr_sel`=1, low 8 bits) other than 0x01 program flash word, 0x02 erase flash sector, 0x03 program EEPROM word, 0x04 erase EEPROM sector, 0x05 erase both arrays, 0x06 erase whole flash, 0x07 erase whole EEPROM sets `accerr` one cycle later. A later launch of that code does not run.
- R4: While `accerr` or `fpviol` is set, a launch is refused with no state change. Writing `wr_sel`=5 with data bit 0 set clears `accerr`, and with bit 1 set clears `fpviol`.
- R5: After an accepted launch, `ccif` is low for exactly N+1 cycles, where N is the cycle register (`wr_sel`=6, with 0 treated as 1). `irq` is high in the last of those cycles only.
- R6: When the operation completes, the store is updated. A program stores the data word at the address. A sector erase sets the aligned group of SECT words that holds the address to all ones. A whole-array erase sets one array to all ones, and erase-both sets both arrays.
- R7: A flash program or flash sector erase with address at or above PROT_BASE sets `fpviol` and does not run.
- R8: A read of an array that the running operation targets (erase-both targets both) returns `rd_valid`=1, `rd_invalid`=1 and data 0, and sets both `sfd` and `dfd`. The two flags stay set until written 1 (`wr_sel`=5, bit 2 for `sfd`, bit 3 for `dfd`).
- R9: A read while idle always returns valid stored data. A normal-margin flash read while an EEPROM program or sector erase runs returns valid stored data.
- R10: A margin flash read during an EEPROM program or sector erase, and any EEPROM read during a flash program or sector erase, give `bus_err` and no valid data.
- R11: While a whole-array or erase-both operation runs, a read of the other array gives `bus_err`.
- R12: A write to the command, address, data or launch register while busy gives `bus_err` and is ignored. The running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select: 0 divider, 1 command, 2 address, 3 data, 4 launch, 5 flag clear, 6 cycle count |
| wr_data | input | WIDTH | Host write data |
| rd_en | input | 1 | Array read request |
| rd_arr | input | 1 | Read target: 0 flash, 1 EEPROM |
| rd_addr | input | AW | Read word address |
| rd_margin | input | 1 | Read is a margin read |
| rd_data | output | WIDTH | Read data, one cycle after request |
| rd_valid | output | 1 | Read answered |
| rd_invalid | output | 1 | Answered read carries invalid data |
| bus_err | output | 1 | Request refused, one-cycle pulse |
| ccif | output | 1 | Command complete / idle |
| irq | output | 1 | Completion pulse |
| accerr | output | 1 | Access error flag |
| fpviol | output | 1 | Protection violation flag |
| sfd | output | 1 | Single-bit fault flag |
| dfd | output | 1 | Double-bit fault flag |

## Verification
The bench counts the exact busy length, with a zero cycle count treated as one, and the position of the interrupt pulse. A counter off by one would report one cycle too many or too few, or would put `irq` after `ccif` has risen. It checks read-while-write from both sides of the allowed overlap: a normal flash read must return data, while a margin flash read and an EEPROM read during a flash program must be refused. A design that compared the wrong array would let through reads that should be refused, or refuse reads that should be allowed. The bench also checks that writes made while busy and launches made while a flag is set leave stored words unchanged, and that sector erase leaves the word just past its aligned group untouched.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam logic [2:0] SEL_DIV  = 3'd0;
    localparam logic [2:0] SEL_CMD  = 3'd1;
    localparam logic [2:0] SEL_ADDR = 3'd2;
    localparam logic [2:0] SEL_DATA = 3'd3;
    localparam logic [2:0] SEL_GO   = 3'd4;
    localparam logic [2:0] SEL_CLR  = 3'd5;
    localparam logic [2:0] SEL_CYC  = 3'd6;

    localparam logic [7:0] CMD_PGM_F = 8'h01;
    localparam logic [7:0] CMD_ERS_F = 8'h02;
    localparam logic [7:0] CMD_PGM_E = 8'h03;
    localparam logic [7:0] CMD_ERS_E = 8'h04;
    localparam logic [7:0] CMD_ALL   = 8'h05;
    localparam logic [7:0] CMD_BLK_F = 8'h06;
    localparam logic [7:0] CMD_BLK_E = 8'h07;

    typedef enum logic [1:0] {S_IDLE, S_EXEC, S_COMMIT} seq_state_e;
    typedef enum logic [1:0] {RD_OK, RD_CLASH, RD_DENY} rd_verdict_e;

    function automatic logic cmd_known(input logic [7:0] c);
        return (c >= CMD_PGM_F) && (c <= CMD_BLK_E);
    endfunction

    function automatic logic cmd_hits_flash(input logic [7:0] c);
        return (c == CMD_PGM_F) || (c == CMD_ERS_F) || (c == CMD_ALL) || (c == CMD_BLK_F);
    endfunction

    function automatic logic cmd_hits_eep(input logic [7:0] c);
        return (c == CMD_PGM_E) || (c == CMD_ERS_E) || (c == CMD_ALL) || (c == CMD_BLK_E);
    endfunction

    function automatic logic cmd_is_mass(input logic [7:0] c);
        return (c == CMD_ALL) || (c == CMD_BLK_F) || (c == CMD_BLK_E);
    endfunction

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int AW        = 4,
    parameter int CNT_W     = 8,
    parameter int DEF_CYC   = 4,
    parameter int PROT_BASE = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic             commit,
    output logic [7:0]       cmd,
    output logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] data,
    output logic             accerr,
    output logic             fpviol,
    output logic             wr_err
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cyc_q;
    logic [7:0]       cmd_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] data_q;
    logic             div_ok_q, accerr_q, fpviol_q, wr_err_q;
    logic             idle, go, flags_up, prot_hit, start;

    assign idle     = (state_q == S_IDLE);
    assign go       = wr_en && (wr_sel == SEL_GO);
    assign flags_up = accerr_q || fpviol_q;
    assign prot_hit = ((cmd_q == CMD_PGM_F) || (cmd_q == CMD_ERS_F)) &&
                      ({1'b0, addr_q} >= (AW+1)'(PROT_BASE));
    assign start    = go && idle && !flags_up && div_ok_q && cmd_known(cmd_q) && !prot_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_EXEC;
            S_EXEC:   if (cnt_q <= CNT_W'(1)) state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start)
                cnt_q <= (cyc_q == '0) ? CNT_W'(1) : cyc_q;
            else if (state_q == S_EXEC)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q    <= CNT_W'(DEF_CYC);
            cmd_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            div_ok_q <= 1'b0;
            accerr_q <= 1'b0;
            fpviol_q <= 1'b0;
            wr_err_q <= 1'b0;
        end else begin
            wr_err_q <= wr_en && !idle &&
                        ((wr_sel == SEL_CMD) || (wr_sel == SEL_ADDR) ||
                         (wr_sel == SEL_DATA) || (wr_sel == SEL_GO));
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_DIV: div_ok_q <= 1'b1;
                    SEL_CYC: cyc_q <= wr_data[CNT_W-1:0];
                    SEL_CLR: begin
                        if (wr_data[0]) accerr_q <= 1'b0;
                        if (wr_data[1]) fpviol_q <= 1'b0;
                    end
                    SEL_CMD: if (idle) begin
                        cmd_q <= wr_data[7:0];
                        if (!cmd_known(wr_data[7:0])) accerr_q <= 1'b1;
                    end
                    SEL_ADDR: if (idle) addr_q <= wr_data[AW-1:0];
                    SEL_DATA: if (idle) data_q <= wr_data;
                    SEL_GO: if (idle && !flags_up) begin
                        if (!div_ok_q || !cmd_known(cmd_q)) accerr_q <= 1'b1;
                        else if (prot_hit)                  fpviol_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy   = !idle;
    assign commit = (state_q == S_COMMIT);
    assign cmd    = cmd_q;
    assign addr   = addr_q;
    assign data   = data_q;
    assign accerr = accerr_q;
    assign fpviol = fpviol_q;
    assign wr_err = wr_err_q;

endmodule

// File: rtl/fcmd_store.sv
module fcmd_store
    import fcmd_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    parameter int SECT  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [7:0]               cmd,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         data,
    input  logic                     rd_arr,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_word
);

    localparam int AW = $clog2(DEPTH);
    localparam int SB = $clog2(SECT);

    logic [WIDTH-1:0] words [2*DEPTH];

    for (genvar a = 0; a < 2; a++) begin : g_arr
        localparam logic [7:0] PCODE = (a == 0) ? CMD_PGM_F : CMD_PGM_E;
        localparam logic [7:0] SCODE = (a == 0) ? CMD_ERS_F : CMD_ERS_E;
        localparam logic [7:0] BCODE = (a == 0) ? CMD_BLK_F : CMD_BLK_E;
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            localparam logic [AW-1:0] IDX = AW'(i);
            logic [WIDTH-1:0] word_q;
            logic             pgm, ers;
            assign pgm = (cmd == PCODE) && (addr == IDX);
            assign ers = ((cmd == SCODE) && ((addr >> SB) == (IDX >> SB))) ||
                         (cmd == BCODE) || (cmd == CMD_ALL);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    word_q <= '1;
                else if (commit && ers)
                    word_q <= '1;
                else if (commit && pgm)
                    word_q <= data;
            end
            assign words[a*DEPTH+i] = word_q;
        end
    end

    assign rd_word = words[{rd_arr, rd_addr}];

endmodule

// File: rtl/fcmd_rdarb.sv
module fcmd_rdarb
    import fcmd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_arr,
    input  logic             rd_margin,
    input  logic             busy,
    input  logic [7:0]       cmd,
    input  logic [WIDTH-1:0] mem_word,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_invalid,
    output logic             rd_err,
    output logic             sfd,
    output logic             dfd
);

    rd_verdict_e verdict;
    logic        same_arr, clr_s, clr_d;

    assign same_arr = rd_arr ? cmd_hits_eep(cmd) : cmd_hits_flash(cmd);
    assign clr_s    = wr_en && (wr_sel == SEL_CLR) && wr_data[2];
    assign clr_d    = wr_en && (wr_sel == SEL_CLR) && wr_data[3];

    always_comb begin
        if (!busy)                verdict = RD_OK;
        else if (same_arr)        verdict = RD_CLASH;
        else if (cmd_is_mass(cmd)) verdict = RD_DENY;
        else if (rd_arr)          verdict = RD_DENY;
        else if (rd_margin)       verdict = RD_DENY;
        else                      verdict = RD_OK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            rd_invalid <= 1'b0;
            rd_err     <= 1'b0;
            sfd        <= 1'b0;
            dfd        <= 1'b0;
        end else begin
            rd_valid   <= rd_en && (verdict != RD_DENY);
            rd_invalid <= rd_en && (verdict == RD_CLASH);
            rd_err     <= rd_en && (verdict == RD_DENY);
            rd_data    <= (rd_en && (verdict == RD_OK)) ? mem_word : '0;
            if (rd_en && (verdict == RD_CLASH)) begin
                sfd <= 1'b1;
                dfd <= 1'b1;
            end else begin
                if (clr_s) sfd <= 1'b0;
                if (clr_d) dfd <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int DEPTH     = 16,
    parameter int SECT      = 4,
    parameter int CNT_W     = 8,
    parameter int DEF_CYC   = 4,
    parameter int PROT_BASE = 12,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_arr,
    input  logic [AW-1:0]    rd_addr,
    input  logic             rd_margin,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_invalid,
    output logic             bus_err,
    output logic             ccif,
    output logic             irq,
    output logic             accerr,
    output logic             fpviol,
    output logic             sfd,
    output logic             dfd
);

    logic             busy, commit, wr_err, rd_err;
    logic [7:0]       cmd;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] data, mem_word;

    fcmd_seq #(
        .WIDTH(WIDTH), .AW(AW), .CNT_W(CNT_W), .DEF_CYC(DEF_CYC), .PROT_BASE(PROT_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .commit(commit), .cmd(cmd), .addr(addr), .data(data),
        .accerr(accerr), .fpviol(fpviol), .wr_err(wr_err)
    );

    fcmd_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SECT(SECT)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(cmd), .addr(addr), .data(data),
        .rd_arr(rd_arr), .rd_addr(rd_addr), .rd_word(mem_word)
    );

    fcmd_rdarb #(.WIDTH(WIDTH)) u_rdarb (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_arr(rd_arr), .rd_margin(rd_margin),
        .busy(busy), .cmd(cmd), .mem_word(mem_word),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_invalid(rd_invalid),
        .rd_err(rd_err), .sfd(sfd), .dfd(dfd)
    );

    assign bus_err = wr_err || rd_err;
    assign ccif    = !busy;
    assign irq     = commit;

endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk
    import fcmd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_en,
    input logic             ccif,
    input logic             irq,
    input logic             accerr,
    input logic             fpviol,
    input logic             sfd,
    input logic             dfd,
    input logic             rd_valid,
    input logic             rd_invalid,
    input logic             bus_err
);

    AST_BUSY_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ccif) |-> $past(wr_en && (wr_sel == SEL_GO))); // R5

    AST_IRQ_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ccif) |-> $past(irq)); // R5

    AST_FLAG_BLOCKS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accerr || fpviol) && ccif |=> ccif); // R4

    AST_INVALID_MARKS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid |-> rd_valid && sfd && dfd); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sfd && !(wr_en && (wr_sel == SEL_CLR) && wr_data[2]) |=> sfd); // R8

    AST_IDLE_READ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && ccif && !wr_en |=> rd_valid && !rd_invalid && !bus_err); // R9

endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .ccif(ccif), .irq(irq), .accerr(accerr), .fpviol(fpviol),
    .sfd(sfd), .dfd(dfd), .rd_valid(rd_valid), .rd_invalid(rd_invalid), .bus_err(bus_err)
);

// File: tb/sim_fcmd_ctrl.sv
`timescale 1ns/1ps
module sim_fcmd_ctrl;

    localparam int W = 16;
    localparam logic [2:0] K_DIV = 0, K_CMD = 1, K_ADDR = 2, K_DATA = 3,
                           K_GO = 4, K_CLR = 5, K_CYC = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, rd_arr = 1'b0, rd_margin = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [W-1:0] rd_data;
    logic rd_valid, rd_invalid, bus_err, ccif, irq, accerr, fpviol, sfd, dfd;

    int n_chk = 0, n_err = 0;
    logic [W-1:0] r_data;
    logic r_valid, r_inv, r_err, w_err;
    int busy_n;
    logic last_irq;

    always #4 clk = ~clk;

    fcmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_arr(rd_arr), .rd_addr(rd_addr), .rd_margin(rd_margin),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_invalid(rd_invalid), .bus_err(bus_err),
        .ccif(ccif), .irq(irq), .accerr(accerr), .fpviol(fpviol), .sfd(sfd), .dfd(dfd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        w_err = bus_err;
    endtask

    task automatic rd(input logic arr, input logic [3:0] a, input logic mg);
        rd_en = 1'b1; rd_arr = arr; rd_addr = a; rd_margin = mg;
        @(negedge clk);
        rd_en = 1'b0; rd_margin = 1'b0;
        r_data = rd_data; r_valid = rd_valid; r_inv = rd_invalid; r_err = bus_err;
    endtask

    task automatic launch(input logic [7:0] c, input logic [3:0] a, input logic [W-1:0] d);
        wr(K_CMD, {8'h00, c});
        wr(K_ADDR, {12'h000, a});
        wr(K_DATA, d);
        wr(K_GO, '0);
    endtask

    task automatic wait_done();
        busy_n = 0; last_irq = 1'b0;
        while (!ccif && busy_n < 1000) begin
            busy_n++; last_irq = irq;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 ccif", ccif, 1); chk("R1 accerr", accerr, 0); chk("R1 fpviol", fpviol, 0);
        chk("R1 sfd", sfd, 0); chk("R1 dfd", dfd, 0); chk("R1 bus_err", bus_err, 0);
        rd(0, 4'd0, 0); chk("R1 flash erased", r_data, 16'hFFFF); chk("R1 valid", r_valid, 1);
        rd(1, 4'd9, 0); chk("R1 eeprom erased", r_data, 16'hFFFF);
    endtask

    task automatic t_no_divider();
        launch(8'h01, 4'd2, 16'h1234);
        chk("R2 accerr", accerr, 1); chk("R2 no run", ccif, 1);
        rd(0, 4'd2, 0); chk("R2 word unchanged", r_data, 16'hFFFF);
        wr(K_CLR, 16'h0001); chk("R4 accerr cleared", accerr, 0);
    endtask

    task automatic t_bad_code();
        wr(K_DIV, 16'h0013);
        wr(K_CMD, 16'h003F); chk("R3 accerr", accerr, 1);
        wr(K_GO, '0); chk("R3 no run", ccif, 1);
        wr(K_CLR, 16'h0001); chk("R4 clear", accerr, 0);
        wr(K_GO, '0); chk("R3 stale code refused", accerr, 1);
        wr(K_CLR, 16'h0001);
    endtask

    task automatic t_program_timing();
        wr(K_CYC, 16'd3);
        launch(8'h01, 4'd2, 16'h1234);
        chk("R5 busy after launch", ccif, 0);
        wait_done();
        chk("R5 busy length", busy_n, 4); chk("R5 irq last", last_irq, 1);
        chk("R5 irq dropped", irq, 0);
        rd(0, 4'd2, 0); chk("R6 program flash", r_data, 16'h1234);
        wr(K_CYC, 16'd0);
        launch(8'h03, 4'd5, 16'hABCD);
        wait_done(); chk("R5 zero count", busy_n, 2);
        rd(1, 4'd5, 0); chk("R6 program eeprom", r_data, 16'hABCD);
    endtask

    task automatic t_read_while_write();
        wr(K_CYC, 16'd20);
        launch(8'h03, 4'd1, 16'h5555);
        rd(0, 4'd2, 0); chk("R9 flash read ok", r_data, 16'h1234);
        chk("R9 valid", r_valid, 1); chk("R9 no err", r_err, 0);
        rd(0, 4'd2, 1); chk("R10 margin refused", r_err, 1); chk("R10 no valid", r_valid, 0);
        rd(1, 4'd5, 0); chk("R8 clash valid", r_valid, 1); chk("R8 clash invalid", r_inv, 1);
        chk("R8 clash data", r_data, 0); chk("R8 sfd", sfd, 1); chk("R8 dfd", dfd, 1);
        wr(K_CMD, 16'h0002); chk("R12 cmd while busy", w_err, 1);
        wr(K_DATA, 16'h0000); chk("R12 data while busy", w_err, 1);
        wait_done();
        rd(1, 4'd1, 0); chk("R12 op unchanged", r_data, 16'h5555);
        chk("R8 sfd sticky", sfd, 1);
        wr(K_CLR, 16'h0004); chk("R8 sfd clr", sfd, 0); chk("R8 dfd kept", dfd, 1);
        wr(K_CLR, 16'h0008); chk("R8 dfd clr", dfd, 0);
    endtask

    task automatic t_flash_busy();
        launch(8'h01, 4'd4, 16'h4444);
        rd(1, 4'd5, 0); chk("R10 eeprom read refused", r_err, 1);
        wr(K_GO, '0); chk("R12 launch while busy", w_err, 1);
        wait_done();
        rd(1, 4'd5, 0); chk("R10 eeprom intact", r_data, 16'hABCD);
        rd(0, 4'd4, 0); chk("R6 flash 4", r_data, 16'h4444);
    endtask

    task automatic t_protect();
        launch(8'h01, 4'd13, 16'h0BAD);
        chk("R7 fpviol", fpviol, 1); chk("R7 no run", ccif, 1);
        rd(0, 4'd13, 0); chk("R7 word untouched", r_data, 16'hFFFF);
        wr(K_ADDR, 16'd6); wr(K_GO, '0); chk("R4 refused while fpviol", ccif, 1);
        rd(0, 4'd6, 0); chk("R4 no program", r_data, 16'hFFFF);
        wr(K_CLR, 16'h0002); chk("R4 fpviol clr", fpviol, 0);
    endtask

    task automatic t_erase();
        launch(8'h02, 4'd2, 16'h0000); wait_done();
        rd(0, 4'd2, 0); chk("R6 sector erased", r_data, 16'hFFFF);
        rd(0, 4'd4, 0); chk("R6 next sector kept", r_data, 16'h4444);
        launch(8'h07, 4'd0, 16'h0000);
        rd(0, 4'd4, 0); chk("R11 flash during block erase", r_err, 1);
        rd(1, 4'd0, 0); chk("R8 eeprom clash", r_inv, 1);
        wait_done();
        rd(1, 4'd5, 0); chk("R6 eeprom block erased", r_data, 16'hFFFF);
        rd(0, 4'd4, 0); chk("R6 flash kept", r_data, 16'h4444);
        wr(K_CLR, 16'h000C);
        launch(8'h05, 4'd0, 16'h0000);
        rd(0, 4'd4, 0); chk("R8 flash clash on erase-all", r_inv, 1);
        wait_done();
        rd(0, 4'd4, 0); chk("R6 erase all", r_data, 16'hFFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_divider();
        t_bad_code();
        t_program_timing();
        t_read_while_write();
        t_flash_busy();
        t_protect();
        t_erase();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule